// File: doc/BRIEF.md
# Forwarded-Clock Multi-Ratio Serial Channel

This block models one serial link lane that carries a companion clock line next to the data line. The transmit half takes a parallel word once per word period and sends it out one bit per clock cycle. Each channel picks its ratio at run time: 4, 7 or 8 bits per word, or a 1:1 pass-through. The companion clock line is high for the first half of each word's bit slots, rounded down. Its rising edge therefore marks where a word begins. Bits leave in a rotated order. The first slot after the rising edge carries bit N/2-1, then the sequence counts down, and after bit 0 it wraps to bit N-1.

The receive half watches the companion clock line and takes the start of each word from its rising edge. It undoes the rotation to rebuild the word and presents it with a one-cycle valid pulse. A lock flag rises once two correctly framed words have arrived in a row. Each half has its own enable. A disabled transmitter parks its lines at zero and raises an active-low output-enable flag. A disabled receiver holds its outputs at zero. The whole model runs on one clock at the serial bit rate. A one-cycle load strobe stands in for the parallel clock edge.

Top module: `fcs_channel`

## Requirements
- R1: While rst_n is low and both enables are low, tx_load, tx_ser_data, tx_ser_clk, rx_word, rx_valid and rx_lock are 0, and tx_oe_n is 1.
- R2: While the transmitter is enabled in a word mode, tx_load is high for one cycle in every N cycles, in the last bit slot. The clock edge that ends that cycle captures tx_word and the ratio field, and the new word's slot 0 starts in the next cycle.
- R3: The ratio field encodes 00 as 4:1, 01 as 7:1, 10 as 8:1 and 11 as 1:1. In 8:1 mode, slots 0 to 7 carry word bits 3,2,1,0,7,6,5,4.
- R4: In 4:1 mode the slots carry bits 1,0,3,2. In 7:1 mode they carry bits 2,1,0,6,5,4,3. Word bits at and above N are not sent.
- R5: tx_ser_clk is high in slots 0 to floor(N/2)-1 of each word and low in the rest: 2 of 4, 3 of 7, 4 of 8.
- R6: In 1:1 mode, tx_ser_data equals tx_word bit 0 in the same cycle, tx_ser_clk and tx_load stay 0, rx_word equals rx_ser_data in bit 0 with zeros above it in the same cycle, and rx_valid and rx_lock stay 0.
- R7: With tx_en low, tx_ser_data, tx_ser_clk and tx_load are 0 and tx_oe_n is 1 in the same cycle. With rx_en low, rx_word, rx_valid and rx_lock are 0 in the same cycle.
- R8: The receiver treats a sample in which rx_ser_clk is 1 after being 0 as slot 0. Each bit goes back to its position. The completed word appears on rx_word with rx_valid high for one cycle, starting in the cycle after the edge that sampled the last slot. rx_word changes at no other time while the receiver is enabled in a word mode.
- R9: rx_lock rises together with the valid pulse of the second consecutive correctly framed word. It falls when the rising clock edge is missing after the last slot, or when a rising edge arrives before the last slot.
- R10: A change of either ratio field while its half is enabled takes effect only at a word boundary. When the receiver's ratio changes, it drops lock, realigns on the next rising clock edge and locks again after two framed words.
- R11: In the first cycle after tx_en rises, and in the first cycle after leaving 1:1 mode, tx_load is high. The first word therefore starts one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; low parks the transmit lines |
| tx_ratio | input | 2 | Transmit ratio field (00 4:1, 01 7:1, 10 8:1, 11 1:1) |
| tx_word | input | WORD_W | Parallel transmit word, captured when tx_load is high |
| tx_load | output | 1 | Word strobe: the clock edge that ends this cycle captures tx_word |
| tx_ser_data | output | 1 | Serial data line |
| tx_ser_clk | output | 1 | Forwarded clock line marking word boundaries |
| tx_oe_n | output | 1 | High while the transmit lines are parked |
| rx_en | input | 1 | Receive enable |
| rx_ratio | input | 2 | Receive ratio field, same encoding as tx_ratio |
| rx_ser_data | input | 1 | Incoming serial data line |
| rx_ser_clk | input | 1 | Incoming forwarded clock line |
| rx_word | output | WORD_W | Rebuilt parallel word |
| rx_valid | output | 1 | One-cycle pulse when rx_word is updated |
| rx_lock | output | 1 | Word framing is locked |

## Verification
The transmit lines show slot k of a word in the k-th cycle after the edge that captured the word, so data and clock line are due one cycle after the load edge. A word looped back into the receiver reaches rx_word N cycles after its capture edge, that is, one cycle after its last slot is sampled. rx_lock is due on that same cycle for the second framed word. Pass-through and disabled outputs follow the inputs within the same cycle. The bench applies inputs just after the falling edge and compares every output one time unit later against a behavioural model that steps once per cycle. Each cycle's comparison therefore meets the output exactly where the register count above puts it. Framing faults come from masking one forwarded-clock sample, and bit errors from flipping one data sample.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int MAX_RATIO = 8;
  localparam int SLOT_W    = $clog2(MAX_RATIO);

  typedef enum logic [1:0] {
    RATIO4 = 2'd0,
    RATIO7 = 2'd1,
    RATIO8 = 2'd2,
    PASS1  = 2'd3
  } ratio_e;

  function automatic int ratio_len(ratio_e m);
    case (m)
      RATIO4:  return 4;
      RATIO7:  return 7;
      RATIO8:  return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [SLOT_W-1:0] last_slot(ratio_e m);
    return SLOT_W'(ratio_len(m) - 1);
  endfunction

  function automatic logic [SLOT_W-1:0] high_slots(ratio_e m);
    return SLOT_W'(ratio_len(m) / 2);
  endfunction

  // word bit carried by slot k: count down from half-1, wrap to the top bit
  function automatic logic [SLOT_W-1:0] bit_at(ratio_e m, logic [SLOT_W-1:0] k);
    int n;
    int h;
    int r;
    n = ratio_len(m);
    h = n / 2;
    if (int'(k) < h) r = h - 1 - int'(k);
    else             r = n + h - 1 - int'(k);
    return SLOT_W'(r);
  endfunction

endpackage

// File: rtl/fcs_tx_lane.sv
module fcs_tx_lane
  import fcs_pkg::*;
#(
  parameter int WORD_W = fcs_pkg::MAX_RATIO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  ratio_e            mode_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              load_o,
  output logic              ser_data_o,
  output logic              ser_clk_o,
  output logic              oe_n_o
);

  ratio_e              mode_q, mode_n;
  logic [SLOT_W-1:0]   slot_q, slot_n;
  logic [WORD_W-1:0]   word_q, word_n;
  logic                boundary;

  assign boundary = (mode_q != PASS1) && (slot_q == last_slot(mode_q));
  assign load_o   = en_i && boundary;

  always_comb begin
    mode_n = mode_q;
    slot_n = slot_q;
    word_n = word_q;
    if (!en_i || mode_q == PASS1) begin
      mode_n = mode_i;
      slot_n = last_slot(mode_i);
      word_n = '0;
    end else if (boundary) begin
      mode_n = mode_i;
      slot_n = '0;
      word_n = word_i;
    end else begin
      slot_n = slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RATIO4;
      slot_q <= last_slot(RATIO4);
      word_q <= '0;
    end else begin
      mode_q <= mode_n;
      slot_q <= slot_n;
      word_q <= word_n;
    end
  end

  always_comb begin
    if (!en_i) begin
      ser_data_o = 1'b0;
      ser_clk_o  = 1'b0;
      oe_n_o     = 1'b1;
    end else if (mode_q == PASS1) begin
      ser_data_o = word_i[0];
      ser_clk_o  = 1'b0;
      oe_n_o     = 1'b0;
    end else begin
      ser_data_o = word_q[bit_at(mode_q, slot_q)];
      ser_clk_o  = (slot_q < high_slots(mode_q));
      oe_n_o     = 1'b0;
    end
  end

  assert_slot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != PASS1) |-> (slot_q <= last_slot(mode_q)));

  assert_clk_high_after_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (!en_i || mode_q == PASS1 || ser_clk_o));

  assert_ratio_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_q != PASS1 && !load_o) |=> $stable(mode_q));

endmodule

// File: rtl/fcs_rx_lane.sv
module fcs_rx_lane
  import fcs_pkg::*;
#(
  parameter int WORD_W     = fcs_pkg::MAX_RATIO,
  parameter int LOCK_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  ratio_e            mode_i,
  input  logic              ser_data_i,
  input  logic              ser_clk_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              lock_o
);

  localparam int GOOD_W = $clog2(LOCK_WORDS + 1);

  ratio_e             mode_q, mode_n;
  logic               aligned_q, aligned_n;
  logic [SLOT_W-1:0]  slot_q, slot_n;
  logic               prev_q, prev_n;
  logic [WORD_W-1:0]  asm_q, asm_n;
  logic [WORD_W-1:0]  word_q, word_n;
  logic               valid_q, valid_n;
  logic               lock_q, lock_n;
  logic [GOOD_W-1:0]  good_q, good_n;
  logic               rise;
  logic [SLOT_W-1:0]  slot_inc;
  logic               active;

  assign rise     = ser_clk_i && !prev_q;
  assign slot_inc = slot_q + SLOT_W'(1);
  assign active   = en_i && (mode_q != PASS1);

  always_comb begin
    mode_n    = mode_q;
    aligned_n = aligned_q;
    slot_n    = slot_q;
    prev_n    = ser_clk_i;
    asm_n     = asm_q;
    word_n    = word_q;
    valid_n   = 1'b0;
    lock_n    = lock_q;
    good_n    = good_q;
    if (!active) begin
      mode_n    = mode_i;
      aligned_n = 1'b0;
      slot_n    = '0;
      prev_n    = en_i && ser_clk_i;
      asm_n     = '0;
      word_n    = '0;
      lock_n    = 1'b0;
      good_n    = '0;
    end else if (rise && (!aligned_q || slot_q == last_slot(mode_q))) begin
      // expected word start
      aligned_n = 1'b1;
      slot_n    = '0;
      asm_n     = '0;
      asm_n[bit_at(mode_q, '0)] = ser_data_i;
    end else if (!aligned_q) begin
      mode_n = mode_i;
    end else if (slot_q == last_slot(mode_q)) begin
      // boundary edge missing
      aligned_n = 1'b0;
      good_n    = '0;
      lock_n    = 1'b0;
    end else if (rise) begin
      // edge too early: restart framing here
      slot_n = '0;
      asm_n  = '0;
      asm_n[bit_at(mode_q, '0)] = ser_data_i;
      good_n = '0;
      lock_n = 1'b0;
    end else begin
      slot_n = slot_inc;
      asm_n[bit_at(mode_q, slot_inc)] = ser_data_i;
      if (slot_inc == last_slot(mode_q)) begin
        word_n  = asm_n;
        valid_n = 1'b1;
        good_n  = (good_q == GOOD_W'(LOCK_WORDS)) ? good_q : good_q + GOOD_W'(1);
        lock_n  = (good_n == GOOD_W'(LOCK_WORDS));
        if (mode_i != mode_q) begin
          mode_n    = mode_i;
          aligned_n = 1'b0;
          good_n    = '0;
          lock_n    = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= RATIO4;
      aligned_q <= 1'b0;
      slot_q    <= '0;
      prev_q    <= 1'b0;
      asm_q     <= '0;
      word_q    <= '0;
      valid_q   <= 1'b0;
      lock_q    <= 1'b0;
      good_q    <= '0;
    end else begin
      mode_q    <= mode_n;
      aligned_q <= aligned_n;
      slot_q    <= slot_n;
      prev_q    <= prev_n;
      asm_q     <= asm_n;
      word_q    <= word_n;
      valid_q   <= valid_n;
      lock_q    <= lock_n;
      good_q    <= good_n;
    end
  end

  always_comb begin
    if (!en_i) begin
      word_o  = '0;
      valid_o = 1'b0;
      lock_o  = 1'b0;
    end else if (mode_q == PASS1) begin
      word_o  = {{(WORD_W-1){1'b0}}, ser_data_i};
      valid_o = 1'b0;
      lock_o  = 1'b0;
    end else begin
      word_o  = word_q;
      valid_o = valid_q;
      lock_o  = lock_q;
    end
  end

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  assert_word_only_on_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> (valid_q || $past(!active)));

  assert_lock_with_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> valid_q);

endmodule

// File: rtl/fcs_channel.sv
module fcs_channel
  import fcs_pkg::*;
#(
  parameter int WORD_W     = fcs_pkg::MAX_RATIO,
  parameter int LOCK_WORDS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic [1:0]        tx_ratio,
  input  logic [WORD_W-1:0] tx_word,
  output logic              tx_load,
  output logic              tx_ser_data,
  output logic              tx_ser_clk,
  output logic              tx_oe_n,
  input  logic              rx_en,
  input  logic [1:0]        rx_ratio,
  input  logic              rx_ser_data,
  input  logic              rx_ser_clk,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_valid,
  output logic              rx_lock
);

  fcs_tx_lane #(
    .WORD_W (WORD_W)
  ) tx_lane_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (tx_en),
    .mode_i     (ratio_e'(tx_ratio)),
    .word_i     (tx_word),
    .load_o     (tx_load),
    .ser_data_o (tx_ser_data),
    .ser_clk_o  (tx_ser_clk),
    .oe_n_o     (tx_oe_n)
  );

  fcs_rx_lane #(
    .WORD_W     (WORD_W),
    .LOCK_WORDS (LOCK_WORDS)
  ) rx_lane_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (rx_en),
    .mode_i     (ratio_e'(rx_ratio)),
    .ser_data_i (rx_ser_data),
    .ser_clk_i  (rx_ser_clk),
    .word_o     (rx_word),
    .valid_o    (rx_valid),
    .lock_o     (rx_lock)
  );

endmodule

// File: tb/fcs_channel_tb_top.sv
module fcs_channel_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_en, rx_en;
  logic [1:0] tx_ratio, rx_ratio;
  logic [7:0] tx_word;
  logic       tx_load, tx_ser_data, tx_ser_clk, tx_oe_n;
  logic       rx_ser_data, rx_ser_clk;
  logic [7:0] rx_word;
  logic       rx_valid, rx_lock;
  logic       inj_c, inj_d;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_ser_data = tx_ser_data ^ inj_d;
  assign rx_ser_clk  = tx_ser_clk & ~inj_c;

  fcs_channel dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_en(tx_en), .tx_ratio(tx_ratio), .tx_word(tx_word),
    .tx_load(tx_load), .tx_ser_data(tx_ser_data), .tx_ser_clk(tx_ser_clk), .tx_oe_n(tx_oe_n),
    .rx_en(rx_en), .rx_ratio(rx_ratio), .rx_ser_data(rx_ser_data), .rx_ser_clk(rx_ser_clk),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_lock(rx_lock)
  );

  // behavioural model state
  int         t_mode, t_slot;
  logic [7:0] t_word;
  int         r_mode, r_slot, r_cnt;
  bit         r_al, r_prev, r_valid, r_lock, r_chg;
  logic [7:0] r_asm, r_word;
  bit         prev_tx_en;
  bit         prev_pass;

  function automatic int nof(int m);
    case (m)
      0: return 4;
      1: return 7;
      2: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int ord(int m, int k);
    int n;
    n = nof(m);
    return ((n/2 - 1 - k) % n + n) % n;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    t_mode = 0; t_slot = 3; t_word = '0;
    r_mode = 0; r_slot = 0; r_cnt = 0;
    r_al = 0; r_prev = 0; r_valid = 0; r_lock = 0; r_chg = 0;
    r_asm = '0; r_word = '0;
  endtask

  task automatic tick();
    logic       e_d, e_c, e_oe, e_ld, e_v, e_l;
    logic [7:0] e_w;
    string      td, tc, to, tl, tw, tk;
    int         n;
    bit         rise;
    #1;
    // ---- expected transmit outputs
    n = nof(t_mode);
    if (!tx_en) begin
      e_d = 0; e_c = 0; e_oe = 1; e_ld = 0; td = "R7"; tc = "R7";
    end else if (t_mode == 3) begin
      e_d = tx_word[0]; e_c = 0; e_oe = 0; e_ld = 0; td = "R6"; tc = "R6";
    end else begin
      e_d = t_word[ord(t_mode, t_slot)];
      e_c = (t_slot < n/2);
      e_oe = 0;
      e_ld = (t_slot == n-1);
      td = (t_mode == 2) ? "R3" : "R4";
      tc = "R5";
    end
    to = "R7";
    tl = (tx_en && (!prev_tx_en || prev_pass)) ? "R11" : "R2";
    // ---- expected receive outputs
    if (!rx_en) begin
      e_w = '0; e_v = 0; e_l = 0; tw = "R7"; tk = "R7";
    end else if (r_mode == 3) begin
      e_w = {7'b0, rx_ser_data}; e_v = 0; e_l = 0; tw = "R6"; tk = "R6";
    end else begin
      e_w = r_word; e_v = r_valid; e_l = r_lock; tw = "R8"; tk = r_chg ? "R10" : "R9";
    end
    if (!rst_n) begin
      td = "R1"; tc = "R1"; to = "R1"; tl = "R1"; tw = "R1"; tk = "R1";
    end
    chk(td, "tx_ser_data", {7'b0, tx_ser_data}, {7'b0, e_d});
    chk(tc, "tx_ser_clk",  {7'b0, tx_ser_clk},  {7'b0, e_c});
    chk(to, "tx_oe_n",     {7'b0, tx_oe_n},     {7'b0, e_oe});
    chk(tl, "tx_load",     {7'b0, tx_load},     {7'b0, e_ld});
    chk(tw, "rx_word",     rx_word,             e_w);
    chk(tw, "rx_valid",    {7'b0, rx_valid},    {7'b0, e_v});
    chk(tk, "rx_lock",     {7'b0, rx_lock},     {7'b0, e_l});
    // ---- advance transmit model
    prev_tx_en = tx_en;
    prev_pass  = (t_mode == 3);
    if (!rst_n) begin
      model_reset();
    end else begin
      if (!tx_en || t_mode == 3) begin
        t_mode = tx_ratio; t_slot = nof(tx_ratio) - 1; t_word = '0;
      end else if (t_slot == nof(t_mode) - 1) begin
        t_mode = tx_ratio; t_slot = 0; t_word = tx_word;
      end else begin
        t_slot++;
      end
      // ---- advance receive model
      r_valid = 0;
      if (!rx_en || r_mode == 3) begin
        r_mode = rx_ratio; r_al = 0; r_slot = 0; r_asm = '0; r_word = '0;
        r_lock = 0; r_cnt = 0; r_prev = rx_en && rx_ser_clk;
      end else begin
        n = nof(r_mode);
        rise = rx_ser_clk && !r_prev;
        if (rise && (!r_al || r_slot == n-1)) begin
          r_al = 1; r_slot = 0; r_asm = '0; r_asm[ord(r_mode, 0)] = rx_ser_data;
        end else if (!r_al) begin
          r_mode = rx_ratio;
        end else if (r_slot == n-1) begin
          r_al = 0; r_cnt = 0; r_lock = 0;
        end else if (rise) begin
          r_slot = 0; r_asm = '0; r_asm[ord(r_mode, 0)] = rx_ser_data; r_cnt = 0; r_lock = 0;
        end else begin
          r_slot++;
          r_asm[ord(r_mode, r_slot)] = rx_ser_data;
          if (r_slot == n-1) begin
            r_word = r_asm; r_valid = 1;
            if (r_cnt < 2) r_cnt++;
            r_lock = (r_cnt >= 2);
            if (rx_ratio != 2'(r_mode)) begin
              r_mode = rx_ratio; r_al = 0; r_cnt = 0; r_lock = 0; r_chg = 1;
            end
          end
        end
        r_prev = rx_ser_clk;
      end
      if (r_lock) r_chg = 0;
    end
    @(negedge clk);
  endtask

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      tx_word = 8'($urandom);
      tick();
    end
  endtask

  initial begin
    rst_n = 0; tx_en = 0; rx_en = 0; tx_ratio = 2'd2; rx_ratio = 2'd2;
    tx_word = 8'h00; inj_c = 0; inj_d = 0;
    prev_tx_en = 0; prev_pass = 0;
    model_reset();
    @(negedge clk);
    run(4);                                    // R1 reset state
    rst_n = 1;
    run(3);
    tx_en = 1; rx_en = 1;                      // R11 first load, R3 8:1 order
    run(30);
    inj_c = 1; tick(); inj_c = 0;              // R9 framing fault
    run(25);
    inj_d = 1; tick(); inj_d = 0;              // corrupted bit
    run(30);
    chk("R9", "lock after 8:1 run", {7'b0, rx_lock}, 8'h01);
    tx_ratio = 2'd1; rx_ratio = 2'd1;          // R4 7:1, R10 change
    run(60);
    chk("R10", "relock at 7:1", {7'b0, rx_lock}, 8'h01);
    tx_ratio = 2'd0; rx_ratio = 2'd0;          // R4 4:1
    run(40);
    chk("R10", "relock at 4:1", {7'b0, rx_lock}, 8'h01);
    tx_ratio = 2'd3; rx_ratio = 2'd3;          // R6 bypass
    run(20);
    tx_ratio = 2'd2; rx_ratio = 2'd2;          // R11 leaving bypass
    run(40);
    tx_en = 0;                                 // R7 parked transmitter
    run(12);
    chk("R9", "lock lost without clock", {7'b0, rx_lock}, 8'h00);
    tx_en = 1;
    run(30);
    rx_en = 0;                                 // R7 receiver off
    run(8);
    rx_en = 1;
    run(30);
    tx_ratio = 2'd0;                           // mismatched ratios
    run(30);
    tx_ratio = 2'd2;
    run(40);
    chk("R9", "final lock", {7'b0, rx_lock}, 8'h01);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule